// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers event pulses from a serial-bus controller into a sticky status vector and raises one level-sensitive interrupt line. Each event source has a status bit. The bit sets on a one-cycle pulse and stays set until software writes a 1 to that bit position at the status offset. A mask vector decides which pending bits may reach the interrupt line. A mask bit reads as 1 while its source is blocked.

Software cannot write the mask vector directly. It changes the mask only through two write-only offsets. Writing 1s at the unmask offset lets those sources through. Writing 1s at the block offset stops them again. Status bits keep latching while their source is masked. A source that is already pending therefore reaches the interrupt line as soon as it is unmasked.

The interrupt line is registered. It follows the pending-and-unmasked set one clock later. Both register reads are combinational from stored state.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset every status bit reads 0, the mask reads 0x2FF (every implemented source blocked) and `irq_o` is 0.
- R2: A 1 on `evt_pulse[i]` for an implemented bit i sets status bit i at the next clock edge. The bit stays set after the pulse ends. Implemented bit positions: 0 transfer done, 1 data threshold, 2 no acknowledge, 3 timeout, 4 target ready, 5 receive overflow, 6 transmit overflow, 7 receive underflow, 9 arbitration lost.
- R3: A write at the status offset (0x10) clears every status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R5: Writing 1s at the unmask offset (0x24) clears those mask bits. Writing 1s at the block offset (0x28) sets them. Bits written with 0 keep their value in both cases.
- R6: `irq_o` is 1 in the cycle after any status bit is set while its mask bit is 0, and 0 in the cycle after no such bit exists. It therefore falls one cycle after the last active bit is cleared or blocked.
- R7: Status bits latch while masked. Unmasking a pending source raises `irq_o` one cycle after the unmask write.
- R8: Bit 8 and bits 15:10 always read 0 in both status and mask. An event on bit 8 has no effect, and writes to these positions have no effect.
- R9: Reads at 0x24, at 0x28 and at any unmapped offset return 0. A write at the mask offset (0x20) or at an unmapped offset changes neither the status nor the mask.
- R10: The status read offset is 0x10 and the mask read offset is 0x20. In both, bit i of the read data corresponds to event input bit i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational, 0 when not selected) |
| evt_pulse | input | 10 | One-cycle event pulses, one per source |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume the following about the inputs:
- All inputs are synchronous to `clk` and settle before each rising edge.
- A single access carries one offset, so an unmask and a block never land in the same cycle.
- Unmapped offsets and the bit-8 event input may carry any value.

The stimulus respects these assumptions. It changes inputs only on the falling edge. Its random addresses are drawn from the four mapped offsets plus two unmapped ones. Its random event vectors cover every bit, including the unused one.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    localparam int unsigned EVT_W  = 10;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned ADDR_W = 6;

    localparam logic [EVT_W-1:0]  IMPL_BITS   = 10'h2FF;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_MASK    = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_UNMASK  = 6'h24;
    localparam logic [ADDR_W-1:0] OFS_BLOCK   = 6'h28;

    typedef enum logic [1:0] {
        RD_NONE   = 2'd0,
        RD_STATUS = 2'd1,
        RD_MASK   = 2'd2
    } rd_src_e;

    typedef struct packed {
        logic    wr_clr;
        logic    wr_unmask;
        logic    wr_block;
        rd_src_e rd_src;
    } bus_cmd_t;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned AW = ADDR_W
) (
    input  logic          sel,
    input  logic          we,
    input  logic [AW-1:0] addr,
    output bus_cmd_t      cmd
);
    localparam logic [AW-1:0] A_STAT = AW'(OFS_STATUS);
    localparam logic [AW-1:0] A_MASK = AW'(OFS_MASK);
    localparam logic [AW-1:0] A_UNM  = AW'(OFS_UNMASK);
    localparam logic [AW-1:0] A_BLK  = AW'(OFS_BLOCK);

    always_comb begin
        cmd           = '0;
        cmd.rd_src    = RD_NONE;
        cmd.wr_clr    = sel && we && (addr == A_STAT);
        cmd.wr_unmask = sel && we && (addr == A_UNM);
        cmd.wr_block  = sel && we && (addr == A_BLK);
        if (sel && !we) begin
            if (addr == A_STAT)      cmd.rd_src = RD_STATUS;
            else if (addr == A_MASK) cmd.rd_src = RD_MASK;
        end
    end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int unsigned            W    = 10,
    parameter logic [W-1:0]           IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_clr,
    input  logic [W-1:0] clr_bits,
    input  logic [W-1:0] evt,
    output logic [W-1:0] status
);
    typedef struct packed {
        logic [W-1:0] bits;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < int'(W); i++) begin
            if (!IMPL[i]) begin
                st_d.bits[i] = 1'b0;
            end else if (evt[i]) begin
                st_d.bits[i] = 1'b1;
            end else if (wr_clr && clr_bits[i]) begin
                st_d.bits[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.bits;
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
    parameter int unsigned            W    = 10,
    parameter logic [W-1:0]           IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_unmask,
    input  logic         wr_block,
    input  logic [W-1:0] wbits,
    output logic [W-1:0] mask
);
    typedef struct packed {
        logic [W-1:0] bits;
    } mk_t;

    mk_t mk_d, mk_q;

    always_comb begin
        mk_d = mk_q;
        if (wr_unmask) mk_d.bits = mk_d.bits & ~wbits;
        if (wr_block)  mk_d.bits = mk_d.bits | wbits;
        mk_d.bits = mk_d.bits & IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mk_q.bits <= IMPL;
        else        mk_q      <= mk_d;
    end

    assign mask = mk_q.bits;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned       NUM_EVT = EVT_W,
    parameter int unsigned       DW      = DATA_W,
    parameter int unsigned       AW      = ADDR_W,
    parameter logic [NUM_EVT-1:0] IMPL   = IMPL_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic [NUM_EVT-1:0] evt_pulse,
    output logic               irq_o
);
    localparam int unsigned PAD_W = DW - NUM_EVT;

    bus_cmd_t           cmd;
    logic [NUM_EVT-1:0] status_vec;
    logic [NUM_EVT-1:0] mask_vec;
    logic [NUM_EVT-1:0] wr_bits;

    typedef struct packed {
        logic irq;
    } top_st_t;

    top_st_t top_d, top_q;

    assign wr_bits = bus_wdata[NUM_EVT-1:0];

    irq_bus_decode #(.AW(AW)) u_dec (
        .sel  (bus_sel),
        .we   (bus_we),
        .addr (bus_addr),
        .cmd  (cmd)
    );

    irq_status_bank #(.W(NUM_EVT), .IMPL(IMPL)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_clr   (cmd.wr_clr),
        .clr_bits (wr_bits),
        .evt      (evt_pulse),
        .status   (status_vec)
    );

    irq_mask_bank #(.W(NUM_EVT), .IMPL(IMPL)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_unmask (cmd.wr_unmask),
        .wr_block  (cmd.wr_block),
        .wbits     (wr_bits),
        .mask      (mask_vec)
    );

    always_comb begin
        top_d     = top_q;
        top_d.irq = |(status_vec & ~mask_vec);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    always_comb begin
        unique case (cmd.rd_src)
            RD_STATUS: bus_rdata = {{PAD_W{1'b0}}, status_vec};
            RD_MASK:   bus_rdata = {{PAD_W{1'b0}}, mask_vec};
            default:   bus_rdata = '0;
        endcase
    end

    assign irq_o = top_q.irq;
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk
    import irq_ctrl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [EVT_W-1:0]  evt_pulse,
    input logic [EVT_W-1:0]  status_q,
    input logic [EVT_W-1:0]  mask_q,
    input logic              irq_o
);
    logic clr_wr, mask_wr, zero_rd;

    assign clr_wr  = bus_sel && bus_we && (bus_addr == OFS_STATUS);
    assign mask_wr = bus_sel && bus_we &&
                     ((bus_addr == OFS_UNMASK) || (bus_addr == OFS_BLOCK));
    assign zero_rd = bus_sel && !bus_we &&
                     (bus_addr != OFS_STATUS) && (bus_addr != OFS_MASK);

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        |(evt_pulse & IMPL_BITS) |=> ((status_q & $past(evt_pulse & IMPL_BITS)) == $past(evt_pulse & IMPL_BITS))); // R4

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> (($past(status_q) & ~status_q) == '0)); // R2

    AST_MASK_ONLY_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr |=> $stable(mask_q)); // R9

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(status_q & ~mask_q)))); // R6

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q | mask_q) & ~IMPL_BITS) == '0); // R8

    AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        zero_rd |-> (bus_rdata == '0)); // R9
endmodule

bind irq_status_ctrl irq_status_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_pulse (evt_pulse),
    .status_q  (status_vec),
    .mask_q    (mask_vec),
    .irq_o     (irq_o)
);

// File: tb/irq_status_ctrl_bench.sv
`timescale 1ns/1ps
module irq_status_ctrl_bench;
    localparam logic [9:0] IMPL = 10'h2FF;
    localparam logic [5:0] A_ST = 6'h10, A_MK = 6'h20, A_EN = 6'h24, A_DI = 6'h28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [9:0]  evt_pulse = '0;
    logic        irq_o;

    int n_run = 0, n_fail = 0;
    logic [9:0] st_m, mk_m;
    logic       irq_m;

    always #5 clk = ~clk;

    irq_status_ctrl u_irq_status_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_pulse(evt_pulse), .irq_o(irq_o)
    );

    function automatic logic [9:0] f_st_next(logic [9:0] st, logic clr, logic [9:0] w, logic [9:0] e);
        logic [9:0] r;
        r = clr ? (st & ~w) : st;
        return (r | e) & IMPL;
    endfunction

    function automatic logic [9:0] f_mk_next(logic [9:0] mk, logic en, logic di, logic [9:0] w);
        logic [9:0] r;
        r = mk;
        if (en) r = r & ~w;
        if (di) r = r | w;
        return r & IMPL;
    endfunction

    function automatic logic [15:0] f_read(logic [5:0] a);
        if (a == A_ST) return {6'd0, st_m};
        if (a == A_MK) return {6'd0, mk_m};
        return 16'd0;
    endfunction

    task automatic check(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // called at a falling edge; applies one cycle of stimulus
    task automatic tick(input logic s, input logic w, input logic [5:0] a,
                        input logic [15:0] d, input logic [9:0] e);
        logic wr;
        bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d; evt_pulse = e;
        @(posedge clk);
        wr    = s && w;
        irq_m = |(st_m & ~mk_m);
        st_m  = f_st_next(st_m, wr && a == A_ST, d[9:0], e);
        mk_m  = f_mk_next(mk_m, wr && a == A_EN, wr && a == A_DI, d[9:0]);
        @(negedge clk);
        check(irq_o == irq_m, "R6 irq level", {15'd0, irq_o}, {15'd0, irq_m});
    endtask

    task automatic rd(input logic [5:0] a, input string tag);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; evt_pulse = '0;
        #1;
        check(bus_rdata == f_read(a), tag, bus_rdata, f_read(a));
    endtask

    task automatic idle();
        tick(1'b0, 1'b0, 6'd0, 16'd0, 10'd0);
    endtask

    initial begin
        #1_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        st_m = '0; mk_m = IMPL; irq_m = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(A_ST, "R1 status after reset");
        rd(A_MK, "R1 mask after reset");
        check(irq_o == 1'b0, "R1 irq after reset", {15'd0, irq_o}, 16'd0);
        // R2 latch while masked (R7)
        tick(1'b0, 1'b0, 6'd0, 16'd0, 10'h001);
        idle(); idle();
        rd(A_ST, "R2 sticky status bit 0");
        check(irq_o == 1'b0, "R7 masked source holds irq low", {15'd0, irq_o}, 16'd0);
        // R7 unmask pending -> irq one cycle after
        tick(1'b1, 1'b1, A_EN, 16'h0001, 10'd0);
        check(irq_o == 1'b0, "R7 irq not yet", {15'd0, irq_o}, 16'd0);
        idle();
        check(irq_o == 1'b1, "R7 irq after unmask", {15'd0, irq_o}, 16'd1);
        rd(A_MK, "R5 mask after unmask");
        // R3 write 0 keeps, write 1 clears
        tick(1'b1, 1'b1, A_ST, 16'h0000, 10'd0);
        rd(A_ST, "R3 zero write keeps");
        tick(1'b1, 1'b1, A_ST, 16'h0001, 10'd0);
        rd(A_ST, "R3 one write clears");
        idle();
        check(irq_o == 1'b0, "R6 irq falls after clear", {15'd0, irq_o}, 16'd0);
        // R4 event vs clear same cycle
        tick(1'b1, 1'b1, A_ST, 16'h0008, 10'h008);
        rd(A_ST, "R4 event beats clear");
        // R8 bit 8 event and high write bits ignored
        tick(1'b0, 1'b0, 6'd0, 16'd0, 10'h100);
        rd(A_ST, "R8 bit 8 event ignored");
        tick(1'b1, 1'b1, A_DI, 16'hFFFF, 10'd0);
        rd(A_MK, "R8 mask unused bits zero");
        // R9 direct mask write ignored, zero reads
        tick(1'b1, 1'b1, A_MK, 16'h0000, 10'd0);
        rd(A_MK, "R9 direct mask write ignored");
        rd(A_EN, "R9 unmask offset reads 0");
        rd(A_DI, "R9 block offset reads 0");
        tick(1'b1, 1'b1, 6'h14, 16'hFFFF, 10'd0);
        rd(6'h14, "R9 unmapped reads 0");
        rd(A_ST, "R9 unmapped write no effect");
        // R5 unmask then block
        tick(1'b1, 1'b1, A_EN, 16'h0208, 10'd0);
        rd(A_MK, "R5 unmask bits 3 and 9");
        idle();
        tick(1'b1, 1'b1, A_DI, 16'h0008, 10'd0);
        rd(A_MK, "R5 block bit 3");
        idle();
        check(irq_o == 1'b0, "R6 irq falls after block", {15'd0, irq_o}, 16'd0);
        // R10 arbitration-lost position
        tick(1'b0, 1'b0, 6'd0, 16'd0, 10'h200);
        rd(A_ST, "R10 bit 9 position");
        idle();
        check(irq_o == 1'b1, "R10 bit 9 unmasked raises irq", {15'd0, irq_o}, 16'd1);
        // random phase
        for (int k = 0; k < 400; k++) begin
            logic [5:0] a;
            logic [9:0] e;
            int sel;
            sel = int'($urandom_range(0, 5));
            case (sel)
                0: a = A_ST; 1: a = A_MK; 2: a = A_EN; 3: a = A_DI;
                4: a = 6'h00; default: a = 6'h2C;
            endcase
            e = ($urandom_range(0, 3) == 0) ? 10'($urandom) : 10'd0;
            if ($urandom_range(0, 2) == 0) begin
                rd(a, "R10 random read");
            end
            tick(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, 16'($urandom), e);
        end
        rd(A_ST, "R10 final status");
        rd(A_MK, "R10 final mask");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule